// File: doc/BRIEF.md
# Cyclic DMA Descriptor Sequencer

This block keeps a small bank of DMA descriptors and turns them into a stream of memory request commands for a downstream transport stage. Software programs each descriptor through a write-only register port that runs on its own, slower clock. The writes cross into the engine clock through a toggle handshake. A descriptor carries a start address, an end address, a host pointer, a direction, a transfer size in 32-bit words, a cyclic flag and an enable bit. The data side is a 256-bit FIFO. The block sees only the FIFO's fill level, which it uses to decide when a transfer toward host memory may be issued.

In one-shot mode a descriptor is cut into requests of at most 256 bytes. When the last request has been accepted, the descriptor reports done and disables itself. In cyclic mode the range from the start address up to the end address is used as a ring. The running address wraps back to the start. It halts whenever it reaches the host pointer, and it resumes once software moves the pointer. When more than one descriptor can run, requests from them are interleaved one at a time.

Top module: `dma_desc_seq`

## Requirements
- R1: Register writes are made on `reg_clk` and take effect in the engine clock domain. `reg_field` selects the target: 0 = start address, 1 = end address (exclusive), 2 = host pointer, 3 = control. The control word holds enable in bit 0, direction in bit 1 (1 = FIFO to host), cyclic in bit 2 and the size in 32-bit words in bits 31:8. Writing control loads the running address from the start address and clears done.
- R2: A one-shot descriptor issues requests at consecutive addresses beginning at its start address. Each request length is the smaller of 256 bytes and the bytes still left from size×4. The length is never zero.
- R3: When the last request of a one-shot descriptor is accepted, its `desc_done` bit sets, its `desc_busy` bit clears, and its `irq` bit pulses for exactly one cycle.
- R4: In cyclic mode a request never runs past the end address. The address after a request that ends exactly at the end address is the start address, and each such wrap pulses the descriptor's `irq` bit once.
- R5: In cyclic mode no request is issued while the running address equals the host pointer. A request never crosses a pointer that lies ahead of the running address. Writing a new pointer lets issuing resume.
- R6: A request in the FIFO-to-host direction is issued only when `fifo_words`×32 bytes is at least the request length.
- R7: When several descriptors are eligible, grants rotate round-robin starting after the last granted index, one request at a time.
- R8: Once `cmd_valid` is high, it stays high with address, length, direction and index held until `cmd_ready` is seen.
- R9: After reset `cmd_valid`, `desc_busy`, `desc_done` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset, engine domain |
| reg_clk | input | 1 | Register port clock |
| reg_rst | input | 1 | Synchronous active-high reset, register domain |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | IW | Descriptor index |
| reg_field | input | 2 | Field select |
| reg_wdata | input | AW | Write data |
| fifo_words | input | FCW | 256-bit words available in the outbound FIFO |
| cmd_valid | output | 1 | Request command valid |
| cmd_ready | input | 1 | Transport accepts command |
| cmd_addr | output | AW | Host byte address |
| cmd_len | output | LW | Request length in bytes |
| cmd_to_host | output | 1 | 1 = FIFO to host memory |
| cmd_id | output | IW | Descriptor index of the request |
| desc_busy | output | NDESC | Per-descriptor enable status |
| desc_done | output | NDESC | Per-descriptor completion status |
| irq | output | NDESC | Per-descriptor interrupt pulse |

## Verification
A table of one-shot transfers covers several size patterns: a single full chunk, a full chunk with a short tail, a transfer shorter than one chunk, and several full chunks with a short tail. Together they separate off-by-one errors in chunk length from errors in address stepping. A cyclic run with the pointer set first ahead of the address and then behind it checks the stall, the wrap and the clipping of a request at the pointer. Two further tests cover the remaining rules. A FIFO-to-host transfer is started with the FIFO one word short of the request and then with enough words, which shows the level gating and command hold. Two descriptors enabled together show whether grants alternate.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    typedef enum logic [1:0] {
        FLD_START = 2'd0,
        FLD_END   = 2'd1,
        FLD_PTR   = 2'd2,
        FLD_CTRL  = 2'd3
    } field_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } eng_st_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_DIR_BIT  = 1;
    localparam int CTRL_CYC_BIT  = 2;
    localparam int CTRL_SIZE_LSB = 8;

endpackage

// File: rtl/dma_reg_sync.sv
module dma_reg_sync #(
    parameter int W = 36
) (
    input  logic         reg_clk,
    input  logic         reg_rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         clk,
    input  logic         rst,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    logic         tog;
    logic [W-1:0] hold;
    logic [2:0]   sync;

    always_ff @(posedge reg_clk) begin
        if (reg_rst) begin
            tog  <= 1'b0;
            hold <= '0;
        end else if (we) begin
            hold <= wdata;
            tog  <= ~tog;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync     <= '0;
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            sync    <= {sync[1:0], tog};
            out_vld <= sync[2] ^ sync[1];
            if (sync[2] ^ sync[1]) out_data <= hold;
        end
    end
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic          any,
    output logic [IW-1:0] gnt
);
    always_comb begin
        any = 1'b0;
        gnt = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (!any && req[idx]) begin
                any = 1'b1;
                gnt = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/dma_desc_slot.sv
module dma_desc_slot
    import dma_desc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SW   = 24,
    parameter int MAXB = 256,
    parameter int LW   = 9,
    parameter int FCW  = 8,
    parameter int FW   = 256
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_vld,
    input  field_e         wr_field,
    input  logic [AW-1:0]  wr_data,
    input  logic [FCW-1:0] fifo_words,
    input  logic           upd,
    output logic           elig,
    output logic [AW-1:0]  cur,
    output logic [LW-1:0]  len,
    output logic           to_host,
    output logic           busy,
    output logic           done,
    output logic           irq
);
    logic [AW-1:0] start_a, end_a, ptr;
    logic [SW-1:0] left;
    logic          cyc;
    logic [AW-1:0] cap, to_end, gap, rem_b, fifo_b, nxt;

    always_comb begin
        to_end = end_a - cur;
        gap    = ptr - cur;
        rem_b  = AW'({left, 2'b00});
        fifo_b = AW'(fifo_words) * AW'(FW / 8);
        cap    = AW'(MAXB);
        if (cyc) begin
            if (to_end < cap) cap = to_end;
            if (ptr > cur && gap < cap) cap = gap;
        end else if (rem_b < cap) begin
            cap = rem_b;
        end
        elig = busy && (cap != '0) && !(cyc && cur == ptr)
               && !(to_host && fifo_b < cap);
        len  = cap[LW-1:0];
        nxt  = cur + AW'(len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_a <= '0; end_a <= '0; ptr <= '0; cur <= '0; left <= '0;
            cyc <= 1'b0; to_host <= 1'b0; busy <= 1'b0; done <= 1'b0; irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr_vld) begin
                case (wr_field)
                    FLD_START: start_a <= wr_data;
                    FLD_END:   end_a   <= wr_data;
                    FLD_PTR:   ptr     <= wr_data;
                    default: begin
                        busy    <= wr_data[CTRL_EN_BIT];
                        to_host <= wr_data[CTRL_DIR_BIT];
                        cyc     <= wr_data[CTRL_CYC_BIT];
                        left    <= wr_data[CTRL_SIZE_LSB +: SW];
                        cur     <= start_a;
                        done    <= 1'b0;
                    end
                endcase
            end else if (upd) begin
                if (cyc) begin
                    if (nxt == end_a) begin
                        cur <= start_a;
                        irq <= 1'b1;
                    end else begin
                        cur <= nxt;
                    end
                end else begin
                    cur  <= nxt;
                    left <= left - SW'(len >> 2);
                    if (left == SW'(len >> 2)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        irq  <= 1'b1;
                    end
                end
            end
        end
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                            // R3
    AST_PTR_GUARD: assert property (@(posedge clk) disable iff (rst)
        (upd && cyc) |-> (cur != ptr));                             // R5
endmodule

// File: rtl/dma_desc_seq.sv
module dma_desc_seq
    import dma_desc_pkg::*;
#(
    parameter int NDESC = 4,
    parameter int AW    = 32,
    parameter int SW    = 24,
    parameter int MAXB  = 256,
    parameter int FCW   = 8,
    parameter int FW    = 256,
    localparam int IW   = (NDESC > 1) ? $clog2(NDESC) : 1,
    localparam int LW   = $clog2(MAXB) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_clk,
    input  logic             reg_rst,
    input  logic             reg_we,
    input  logic [IW-1:0]    reg_idx,
    input  logic [1:0]       reg_field,
    input  logic [AW-1:0]    reg_wdata,
    input  logic [FCW-1:0]   fifo_words,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [AW-1:0]    cmd_addr,
    output logic [LW-1:0]    cmd_len,
    output logic             cmd_to_host,
    output logic [IW-1:0]    cmd_id,
    output logic [NDESC-1:0] desc_busy,
    output logic [NDESC-1:0] desc_done,
    output logic [NDESC-1:0] irq
);
    localparam int RW = IW + 2 + AW;

    logic          s_vld;
    logic [RW-1:0] s_data;
    logic [IW-1:0] s_idx;
    field_e        s_field;
    logic [AW-1:0] s_wdata;

    dma_reg_sync #(.W(RW)) u_sync (
        .reg_clk(reg_clk), .reg_rst(reg_rst), .we(reg_we),
        .wdata({reg_idx, reg_field, reg_wdata}),
        .clk(clk), .rst(rst), .out_vld(s_vld), .out_data(s_data)
    );

    assign s_idx   = s_data[RW-1 -: IW];
    assign s_field = field_e'(s_data[AW +: 2]);
    assign s_wdata = s_data[AW-1:0];

    eng_st_e       st;
    logic [IW-1:0] sel, last;
    logic          any;
    logic [IW-1:0] gnt;

    logic [NDESC-1:0] elig, dir_v, upd;
    logic [AW-1:0]    cur_v [NDESC];
    logic [LW-1:0]    len_v [NDESC];

    for (genvar i = 0; i < NDESC; i++) begin : g_slot
        assign upd[i] = (st == ST_ISSUE) && cmd_ready && (sel == IW'(i));
        dma_desc_slot #(.AW(AW), .SW(SW), .MAXB(MAXB), .LW(LW), .FCW(FCW), .FW(FW)) u_slot (
            .clk(clk), .rst(rst),
            .wr_vld(s_vld && s_idx == IW'(i)), .wr_field(s_field), .wr_data(s_wdata),
            .fifo_words(fifo_words), .upd(upd[i]),
            .elig(elig[i]), .cur(cur_v[i]), .len(len_v[i]), .to_host(dir_v[i]),
            .busy(desc_busy[i]), .done(desc_done[i]), .irq(irq[i])
        );
    end

    dma_rr_arb #(.N(NDESC), .IW(IW)) u_arb (
        .req(elig), .last(last), .any(any), .gnt(gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; sel <= '0; last <= IW'(NDESC - 1);
            cmd_valid <= 1'b0; cmd_addr <= '0; cmd_len <= '0;
            cmd_to_host <= 1'b0; cmd_id <= '0;
        end else if (st == ST_IDLE) begin
            if (any) begin
                st          <= ST_ISSUE;
                sel         <= gnt;
                cmd_valid   <= 1'b1;
                cmd_addr    <= cur_v[gnt];
                cmd_len     <= len_v[gnt];
                cmd_to_host <= dir_v[gnt];
                cmd_id      <= gnt;
            end
        end else if (cmd_ready) begin
            st        <= ST_IDLE;
            cmd_valid <= 1'b0;
            last      <= sel;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
            && $stable(cmd_len) && $stable(cmd_id)));               // R8
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_len != '0 && cmd_len <= LW'(MAXB)));      // R2
    AST_FIFO_GATE: assert property (@(posedge clk) disable iff (rst)
        ($rose(cmd_valid) && cmd_to_host)
            |-> (AW'($past(fifo_words)) * AW'(FW / 8) >= AW'(cmd_len)));  // R6
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq));                                             // R3
endmodule

// File: tb/test_dma_desc_seq.sv
module test_dma_desc_seq;
    localparam int NDESC = 4;
    localparam int AW = 32;

    logic clk = 0, reg_clk = 0, rst = 1, reg_rst = 1;
    logic reg_we = 0;
    logic [1:0] reg_idx = 0, reg_field = 0;
    logic [AW-1:0] reg_wdata = 0;
    logic [7:0] fifo_words = 0;
    logic cmd_ready = 1;
    logic cmd_valid, cmd_to_host;
    logic [AW-1:0] cmd_addr;
    logic [8:0] cmd_len;
    logic [1:0] cmd_id;
    logic [NDESC-1:0] desc_busy, desc_done, irq;

    always #2.5 clk = ~clk;
    always #6.5 reg_clk = ~reg_clk;

    dma_desc_seq i_dma_desc_seq (
        .clk(clk), .rst(rst), .reg_clk(reg_clk), .reg_rst(reg_rst),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_field(reg_field), .reg_wdata(reg_wdata),
        .fifo_words(fifo_words), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_to_host(cmd_to_host), .cmd_id(cmd_id),
        .desc_busy(desc_busy), .desc_done(desc_done), .irq(irq)
    );

    int checks = 0, fails = 0, ncmd = 0;
    int irq_cnt [NDESC];
    logic [AW-1:0] log_addr [64];
    int log_len [64], log_id [64], log_dir [64];
    bit finished = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_valid && cmd_ready && ncmd < 64) begin
                log_addr[ncmd] = cmd_addr; log_len[ncmd] = int'(cmd_len);
                log_id[ncmd] = int'(cmd_id); log_dir[ncmd] = int'(cmd_to_host);
                ncmd++;
            end
            for (int i = 0; i < NDESC; i++) if (irq[i]) irq_cnt[i]++;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int fld, input logic [AW-1:0] d);
        @(posedge reg_clk); #1;
        reg_we = 1; reg_idx = 2'(idx); reg_field = 2'(fld); reg_wdata = d;
        @(posedge reg_clk); #1;
        reg_we = 0;
        repeat (5) @(posedge reg_clk);
    endtask

    task automatic clear_log();
        @(negedge clk);
        ncmd = 0;
        for (int i = 0; i < NDESC; i++) irq_cnt[i] = 0;
    endtask

    function automatic logic [AW-1:0] ctrl(input int size, input bit cyc, input bit dir, input bit en);
        return (AW'(size) << 8) | (AW'(cyc) << 2) | (AW'(dir) << 1) | AW'(en);
    endfunction

    // table: start address, size in words (one-shot, memory to FIFO)
    localparam logic [55:0] VEC [4] = '{
        {32'h0001_0000, 24'd64},
        {32'h0002_0000, 24'd100},
        {32'h0003_0000, 24'd8},
        {32'h0004_0000, 24'd200}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NDESC; i++) irq_cnt[i] = 0;
        repeat (4) @(posedge reg_clk);
        #1 rst = 0; reg_rst = 0;
        @(negedge clk);
        // R9 reset state
        chk(cmd_valid == 0, "R9 cmd_valid", cmd_valid, 0);
        chk(desc_busy == 0 && desc_done == 0, "R9 status", {desc_busy, desc_done}, 0);
        chk(irq == 0, "R9 irq", irq, 0);

        // R1 R2 R3: table of one-shot transfers
        for (int v = 0; v < 4; v++) begin
            logic [AW-1:0] st; int sz, total, n, w;
            st = VEC[v][55:24]; sz = int'(VEC[v][23:0]);
            total = sz * 4; n = (total + 255) / 256;
            clear_log();
            wr(0, 0, st);
            wr(0, 3, ctrl(sz, 0, 0, 1));
            w = 0;
            while (!desc_done[0] && w < 2000) begin @(negedge clk); w++; end
            repeat (4) @(negedge clk);
            chk(ncmd == n, "R2 command count", ncmd, n);
            for (int k = 0; k < n && k < ncmd; k++) begin
                int el;
                el = (total - 256 * k) < 256 ? total - 256 * k : 256;
                chk(log_addr[k] == st + AW'(256 * k), "R2 address", log_addr[k], st + AW'(256 * k));
                chk(log_len[k] == el, "R2 length", log_len[k], el);
                chk(log_dir[k] == 0 && log_id[k] == 0, "R1 dir/id", log_dir[k], 0);
            end
            chk(desc_done[0] && !desc_busy[0], "R3 done status", {desc_done[0], desc_busy[0]}, 2);
            chk(irq_cnt[0] == 1, "R3 irq count", irq_cnt[0], 1);
        end

        // R6 R8: FIFO-to-host gating and command hold
        clear_log();
        fifo_words = 7;
        wr(0, 0, 32'h0005_0000);
        wr(0, 3, ctrl(64, 0, 1, 1));
        repeat (100) @(negedge clk);
        chk(ncmd == 0 && cmd_valid == 0, "R6 gated by level", ncmd, 0);
        @(posedge clk); #1; cmd_ready = 0; fifo_words = 8;
        repeat (12) @(negedge clk);
        chk(cmd_valid == 1 && cmd_addr == 32'h0005_0000, "R8 hold valid", cmd_addr, 32'h0005_0000);
        chk(cmd_len == 256 && cmd_to_host == 1, "R8 hold len/dir", cmd_len, 256);
        @(posedge clk); #1; cmd_ready = 1;
        repeat (20) @(negedge clk);
        chk(ncmd == 1 && log_dir[0] == 1, "R6 issued with level", ncmd, 1);
        chk(desc_done[0] == 1, "R3 write done", desc_done[0], 1);
        fifo_words = 0;

        // R4 R5: cyclic ring with host pointer on descriptor 1
        clear_log();
        wr(1, 0, 32'h0000_2000);
        wr(1, 1, 32'h0000_2400);
        wr(1, 2, 32'h0000_2200);
        wr(1, 3, ctrl(0, 1, 0, 1));
        repeat (200) @(negedge clk);
        chk(ncmd == 2, "R5 stall at pointer", ncmd, 2);
        chk(log_addr[0] == 32'h2000 && log_addr[1] == 32'h2100, "R5 addresses", log_addr[1], 32'h2100);
        chk(irq_cnt[1] == 0, "R4 no wrap yet", irq_cnt[1], 0);
        wr(1, 2, 32'h0000_2080);
        repeat (200) @(negedge clk);
        chk(ncmd == 5, "R5 resume count", ncmd, 5);
        chk(log_addr[2] == 32'h2200 && log_addr[3] == 32'h2300, "R4 to end", log_addr[3], 32'h2300);
        chk(log_addr[4] == 32'h2000, "R4 wrap to start", log_addr[4], 32'h2000);
        chk(log_len[4] == 128, "R5 clip at pointer", log_len[4], 128);
        chk(irq_cnt[1] == 1, "R4 wrap irq", irq_cnt[1], 1);
        chk(desc_busy[1] == 1 && desc_done[1] == 0, "R4 still running", desc_busy[1], 1);
        wr(1, 3, ctrl(0, 0, 0, 0));

        // R7: round-robin between descriptors 0 and 1
        clear_log();
        @(posedge clk); #1; cmd_ready = 0;
        wr(0, 0, 32'h0000_3000);
        wr(1, 0, 32'h0000_4000);
        wr(0, 3, ctrl(192, 0, 0, 1));
        wr(1, 3, ctrl(192, 0, 0, 1));
        @(posedge clk); #1; cmd_ready = 1;
        repeat (100) @(negedge clk);
        chk(ncmd == 6, "R7 total", ncmd, 6);
        for (int k = 0; k < 6 && k < ncmd; k++) begin
            logic [AW-1:0] ea;
            ea = ((k % 2) == 0 ? 32'h3000 : 32'h4000) + AW'(256 * (k / 2));
            chk(log_id[k] == (k % 2), "R7 alternation", log_id[k], k % 2);
            chk(log_addr[k] == ea, "R7 address", log_addr[k], ea);
        end
        chk(desc_done[1:0] == 2'b11, "R3 both done", desc_done[1:0], 3);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule